// File: doc/BRIEF.md
# Byte-Stream Command and Record Loader

This block sits behind a host link that hands over one byte per transfer. It parses that byte stream into three kinds of command. A module reset clears the stored record count and restores the default phase. A phase command sets the angle between the two sine channels. A load command fills a record memory with fixed-size amplitude records. Each finished record is written through a plain memory write port, and addresses count up from zero within each load.

There is no byte that marks the end of a record. Record boundaries come only from byte counting: the byte after the last byte of a record is always the first byte of the next record. The load command declares in advance how many records follow. The parser consumes exactly that many records, even those beyond the memory capacity. It then returns to waiting for an opcode.

The byte input is a valid/ready stream. A byte moves only on a clock edge where both `in_valid` and `in_ready` are high. `in_ready` drops for exactly one cycle, the cycle in which the module reset pulse is driven. A source that sees `in_ready` low must hold its byte and its `in_valid` until `in_ready` rises again. The other ports are plain registered signals.

Top module: `cmd_loader`

## Requirements
- R1: While `rst_n` is low and after it is released, `in_ready`=1, `wr_en`=0, `rec_count`=0, `mod_rst`=0 and `xy_phase`=256, the default of 90 degrees on a 1024-step circle.
- R2: The byte sequence 0x02, A, B sets `xy_phase` to {A[1:0], B} in the cycle after B is accepted. Bits 7:2 of A are ignored.
- R3: The sequence 0x03, Chi, Clo is followed by N = {Chi, Clo} records of 7 bytes each. For each stored record, `wr_en` is high for one cycle and `wr_data[55:48]` holds the record's first byte (most significant byte first). `wr_addr` is 0 for the first record of the load and rises by one for each record after it.
- R4: The byte after a record's seventh byte is the first byte of the next record. Records may follow each other back to back with no idle cycle.
- R5: `rec_count` becomes 0 when a load opcode is accepted. It rises by one in the same cycle as each `wr_en`, and equals `wr_addr`+1 during a write. It changes at no other time, except when the module reset command clears it.
- R6: A load holds at most 1000 records. Later records in the same load are consumed but never written, and `rec_count` stays at 1000. After the N-th record the next byte is parsed as an opcode.
- R7: A load with N=0 writes nothing, and the next byte is parsed as an opcode.
- R8: The opcode 0x01 gives, in the following cycle, `mod_rst`=1 for exactly one cycle with `rec_count`=0, `xy_phase`=256 and `in_ready`=0. The byte offered during that cycle is accepted in the next cycle.
- R9: An opcode byte other than 0x01, 0x02 or 0x03 is dropped without any output change, and the byte after it is parsed as an opcode.
- R10: A cycle with `in_valid` low consumes nothing and causes no write. Idle cycles may appear anywhere inside a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is offered on `in_data` |
| in_ready | output | 1 | Block accepts the offered byte this edge |
| in_data | input | 8 | Received byte |
| wr_en | output | 1 | Record memory write strobe |
| wr_addr | output | 10 | Record memory address |
| wr_data | output | 56 | Assembled record, first byte in the top bits |
| rec_count | output | 10 | Records stored by the current load |
| xy_phase | output | 10 | Phase offset of the second channel |
| mod_rst | output | 1 | One-cycle module reset pulse |

## Verification
Two events can fall on the same accepted byte. The seventh byte of record 1000 performs the last permitted write, and the same byte puts the counter into its full state, so every later record is swallowed. The bench provokes this with a back-to-back load of 1002 records. It judges the result by the exact address and data of every write, by a final count of 1000, and by a phase command that must take effect at once after the last swallowed byte. A second overlap occurs when a byte is offered in the cycle of the reset pulse. The bench holds that byte and checks that it is accepted one cycle later.

// File: rtl/cmdld_pkg.sv
package cmdld_pkg;
  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_PHASE_HI,
    ST_PHASE_LO,
    ST_COUNT_HI,
    ST_COUNT_LO,
    ST_RECORD
  } parse_state_t;

  localparam logic [7:0] OPC_RESET = 8'h01;
  localparam logic [7:0] OPC_PHASE = 8'h02;
  localparam logic [7:0] OPC_LOAD  = 8'h03;
endpackage

// File: rtl/cmdld_parser.sv
module cmdld_parser
  import cmdld_pkg::*;
#(
  parameter int REC_BYTES = 7,
  parameter int PHASE_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [7:0]         byte_in,
  output logic               rst_stb,
  output logic               load_stb,
  output logic               phase_stb,
  output logic [PHASE_W-1:0] phase_val,
  output logic               rec_byte_stb,
  output logic               rec_done_stb
);
  localparam int POS_W = (REC_BYTES > 1) ? $clog2(REC_BYTES) : 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(REC_BYTES - 1);

  parse_state_t     state_q;
  logic [7:0]       hi_q;
  logic [15:0]      remain_q;
  logic [POS_W-1:0] pos_q;
  logic [15:0]      pair;

  assign pair      = {hi_q, byte_in};
  assign phase_val = pair[PHASE_W-1:0];

  always_comb begin
    rst_stb      = accept && (state_q == ST_OPCODE) && (byte_in == OPC_RESET);
    load_stb     = accept && (state_q == ST_OPCODE) && (byte_in == OPC_LOAD);
    phase_stb    = accept && (state_q == ST_PHASE_LO);
    rec_byte_stb = accept && (state_q == ST_RECORD);
    rec_done_stb = rec_byte_stb && (pos_q == LAST_POS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_OPCODE;
      hi_q     <= '0;
      remain_q <= '0;
      pos_q    <= '0;
    end else if (accept) begin
      case (state_q)
        ST_OPCODE: begin
          pos_q <= '0;
          if (byte_in == OPC_PHASE)     state_q <= ST_PHASE_HI;
          else if (byte_in == OPC_LOAD) state_q <= ST_COUNT_HI;
          else                          state_q <= ST_OPCODE;
        end
        ST_PHASE_HI: begin
          hi_q    <= byte_in;
          state_q <= ST_PHASE_LO;
        end
        ST_PHASE_LO: state_q <= ST_OPCODE;
        ST_COUNT_HI: begin
          hi_q    <= byte_in;
          state_q <= ST_COUNT_LO;
        end
        ST_COUNT_LO: begin
          remain_q <= pair;
          pos_q    <= '0;
          state_q  <= (pair == 16'd0) ? ST_OPCODE : ST_RECORD;
        end
        ST_RECORD: begin
          if (pos_q == LAST_POS) begin
            pos_q    <= '0;
            remain_q <= remain_q - 16'd1;
            if (remain_q == 16'd1) state_q <= ST_OPCODE;
          end else begin
            pos_q <= pos_q + POS_W'(1);
          end
        end
        default: state_q <= ST_OPCODE;
      endcase
    end
  end
endmodule

// File: rtl/cmdld_assembler.sv
module cmdld_assembler #(
  parameter int REC_BYTES = 7,
  localparam int REC_W    = REC_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [7:0]       byte_in,
  output logic [REC_W-1:0] word_next
);
  localparam int HELD = REC_BYTES - 1;

  logic [7:0] lane [HELD];

  assign word_next[7:0] = byte_in;

  for (genvar k = 0; k < HELD; k++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lane[k] <= '0;
      else if (shift_en) lane[k] <= (k == 0) ? byte_in : lane[(k == 0) ? 0 : k-1];
    end
    assign word_next[(k+1)*8 +: 8] = lane[k];
  end
endmodule

// File: rtl/cmdld_writer.sv
module cmdld_writer #(
  parameter int MAX_RECS  = 1000,
  parameter int REC_W     = 56,
  localparam int ADDR_W   = (MAX_RECS > 1) ? $clog2(MAX_RECS) : 1,
  localparam int CNT_W    = $clog2(MAX_RECS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rec_done,
  input  logic [REC_W-1:0]  word_in,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [REC_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  rec_count
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_RECS);

  logic full;
  assign full = (rec_count == CAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      rec_count <= '0;
    end else begin
      wr_en <= 1'b0;
      if (clear) begin
        rec_count <= '0;
      end else if (rec_done && !full) begin
        wr_en     <= 1'b1;
        wr_addr   <= rec_count[ADDR_W-1:0];
        wr_data   <= word_in;
        rec_count <= rec_count + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/cmd_loader.sv
module cmd_loader #(
  parameter int MAX_RECS   = 1000,
  parameter int REC_BYTES  = 7,
  parameter int PHASE_W    = 10,
  parameter int PHASE_INIT = 256,
  localparam int REC_W     = REC_BYTES * 8,
  localparam int ADDR_W    = (MAX_RECS > 1) ? $clog2(MAX_RECS) : 1,
  localparam int CNT_W     = $clog2(MAX_RECS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [REC_W-1:0]   wr_data,
  output logic [CNT_W-1:0]   rec_count,
  output logic [PHASE_W-1:0] xy_phase,
  output logic               mod_rst
);
  logic               accept;
  logic               rst_stb, load_stb, phase_stb, rec_byte_stb, rec_done_stb;
  logic [PHASE_W-1:0] phase_val;
  logic [REC_W-1:0]   word_next;

  assign in_ready = ~mod_rst;
  assign accept   = in_valid & in_ready;

  cmdld_parser #(.REC_BYTES(REC_BYTES), .PHASE_W(PHASE_W)) u_parser (
    .clk(clk), .rst_n(rst_n), .accept(accept), .byte_in(in_data),
    .rst_stb(rst_stb), .load_stb(load_stb), .phase_stb(phase_stb),
    .phase_val(phase_val), .rec_byte_stb(rec_byte_stb), .rec_done_stb(rec_done_stb)
  );

  cmdld_assembler #(.REC_BYTES(REC_BYTES)) u_asm (
    .clk(clk), .rst_n(rst_n), .shift_en(rec_byte_stb), .byte_in(in_data),
    .word_next(word_next)
  );

  cmdld_writer #(.MAX_RECS(MAX_RECS), .REC_W(REC_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .clear(rst_stb | load_stb), .rec_done(rec_done_stb),
    .word_in(word_next), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rec_count(rec_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xy_phase <= PHASE_W'(PHASE_INIT);
      mod_rst  <= 1'b0;
    end else begin
      mod_rst <= rst_stb;
      if (rst_stb)        xy_phase <= PHASE_W'(PHASE_INIT);
      else if (phase_stb) xy_phase <= phase_val;
    end
  end
endmodule

// File: rtl/cmdld_checks.sv
module cmdld_checks #(
  parameter int MAX_RECS   = 1000,
  parameter int PHASE_W    = 10,
  parameter int PHASE_INIT = 256,
  parameter int ADDR_W     = 10,
  parameter int CNT_W      = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [CNT_W-1:0]   rec_count,
  input logic [PHASE_W-1:0] xy_phase,
  input logic               mod_rst
);
  p_addr_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_addr) < MAX_RECS));

  p_count_tracks_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(rec_count) == 32'(wr_addr) + 1));

  p_count_moves_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((rec_count != $past(rec_count)) && (rec_count != '0)) |-> wr_en);

  p_reset_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mod_rst |-> ((rec_count == '0) && (xy_phase == PHASE_W'(PHASE_INIT))));

  p_reset_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mod_rst |=> !mod_rst);

  p_phase_needs_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xy_phase != $past(xy_phase)) |-> $past(in_valid && in_ready));

  p_idle_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid && in_ready) |-> !wr_en);
endmodule

bind cmd_loader cmdld_checks #(
  .MAX_RECS(MAX_RECS), .PHASE_W(PHASE_W), .PHASE_INIT(PHASE_INIT),
  .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .wr_en(wr_en), .wr_addr(wr_addr), .rec_count(rec_count),
  .xy_phase(xy_phase), .mod_rst(mod_rst)
);

// File: tb/cmd_loader_test.sv
module cmd_loader_test;
  localparam int CAP = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        wr_en;
  logic [9:0]  wr_addr;
  logic [55:0] wr_data;
  logic [9:0]  rec_count;
  logic [9:0]  xy_phase;
  logic        mod_rst;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  int exp_n   = 0;
  int wr_seen = 0;
  logic [55:0] exp_mem [CAP];

  always #5 clk = ~clk;

  cmd_loader uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rec_count(rec_count), .xy_phase(xy_phase), .mod_rst(mod_rst)
  );

  function automatic logic [9:0] exp_phase(input logic [7:0] a, input logic [7:0] b);
    return {a[1:0], b};
  endfunction

  function automatic int stored(input int n);
    return (n < CAP) ? n : CAP;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // record writes: R3 address/data, R4 boundaries, R5 count
  always @(negedge clk) begin
    cyc++;
    if (rst_n && wr_en) begin
      vectors++;
      if (wr_seen >= exp_n) begin
        fails++;
        $display("FAIL R3 unexpected write actual=%0h expected=none", wr_addr);
      end else if (wr_addr != 10'(wr_seen) || wr_data != exp_mem[wr_seen] ||
                   rec_count != 10'(wr_seen + 1)) begin
        fails++;
        $display("FAIL R3/R4/R5 rec %0d actual=%0h/%0h/%0h expected=%0h/%0h/%0h",
                 wr_seen, wr_addr, wr_data, rec_count, wr_seen, exp_mem[wr_seen], wr_seen + 1);
      end
      wr_seen++;
    end
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // returns at the falling edge after the byte was taken
  task automatic send(input logic [7:0] b, input bit gaps);
    if (gaps && ($urandom % 3 == 0)) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic set_phase(input logic [7:0] a, input logic [7:0] b, input bit gaps, input string req);
    send(8'h02, gaps);
    send(a, gaps);
    send(b, gaps);
    check(xy_phase == exp_phase(a, b), req, xy_phase, exp_phase(a, b));
  endtask

  task automatic do_load(input int n, input bit gaps);
    exp_n   = stored(n);
    wr_seen = 0;
    for (int i = 0; i < exp_n; i++) exp_mem[i] = {$urandom, $urandom} & 56'hFF_FFFF_FFFF_FFFF;
    send(8'h03, gaps);
    send(8'(n >> 8), gaps);
    send(8'(n), gaps);
    for (int r = 0; r < n; r++)
      for (int k = 0; k < 7; k++)
        send((r < CAP) ? exp_mem[r][55-8*k -: 8] : 8'($urandom), gaps);
    @(negedge clk);
    @(negedge clk);
    check(wr_seen == exp_n, "R3 write count", wr_seen, exp_n);
    check(rec_count == 10'(exp_n), "R5 rec_count", rec_count, exp_n);
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    check(in_ready && !wr_en && !mod_rst && rec_count == 0 && xy_phase == 10'd256,
          "R1 during reset", {in_ready, wr_en, mod_rst, rec_count, xy_phase}, {3'b100, 10'd0, 10'd256});
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !wr_en && !mod_rst && rec_count == 0 && xy_phase == 10'd256,
          "R1 after reset", {in_ready, wr_en, mod_rst, rec_count, xy_phase}, {3'b100, 10'd0, 10'd256});

    set_phase(8'hFD, 8'h34, 1'b0, "R2 upper bits ignored");
    set_phase(8'h00, 8'h00, 1'b1, "R2 zero phase");

    do_load(3, 1'b0);   // R4 back to back
    do_load(5, 1'b1);   // R10 idle cycles inside frame

    // R7 empty load followed directly by an opcode
    do_load(0, 1'b0);
    set_phase(8'h01, 8'h77, 1'b0, "R7 opcode after empty load");

    // R9 unknown opcodes
    exp_n = 0; wr_seen = 0;
    send(8'h00, 1'b0);
    send(8'hA5, 1'b0);
    send(8'hFF, 1'b0);
    check(xy_phase == 10'h177 && rec_count == 0, "R9 no change", {xy_phase, rec_count}, {10'h177, 10'd0});
    set_phase(8'h03, 8'hFF, 1'b0, "R9 next byte is opcode");

    // R8 module reset after a load
    do_load(4, 1'b0);
    send(8'h01, 1'b0);
    check(mod_rst && !in_ready && rec_count == 0 && xy_phase == 10'd256,
          "R8 reset pulse", {mod_rst, in_ready, rec_count, xy_phase}, {2'b10, 10'd0, 10'd256});
    in_valid = 1'b1;
    in_data  = 8'h02;
    @(posedge clk);
    @(negedge clk);
    check(!mod_rst && in_ready, "R8 pulse one cycle", {mod_rst, in_ready}, 2'b01);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    send(8'h02, 1'b0);
    send(8'hAA, 1'b0);
    check(xy_phase == exp_phase(8'h02, 8'hAA), "R8 held byte accepted", xy_phase, exp_phase(8'h02, 8'hAA));
    do_load(2, 1'b0);   // R3 addresses restart at 0

    // random mix
    for (int it = 0; it < 6; it++) begin
      do_load(1 + ($urandom % 12), 1'($urandom));
      set_phase(8'($urandom), 8'($urandom), 1'($urandom), "R2 random");
    end

    // R6 capacity boundary
    do_load(CAP + 2, 1'b0);
    set_phase(8'h02, 8'h5A, 1'b0, "R6 framing after overflow");
    check(rec_count == 10'(CAP), "R6 count saturates", rec_count, CAP);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule